// File: doc/BRIEF.md
# SIMD Rounding Right-Shift Unit

This unit shifts every lane of a 256-bit vector to the right and rounds the result to nearest. The element size can be 8, 16, 32 or 64 bits. The caller picks whether each lane is unsigned (zero fill) or signed (sign fill). The caller also picks where the shift counts come from: the matching lane of a second vector, or one immediate shared by all lanes.

After a shift by a nonzero count, the last bit shifted out is added back into the lane. A count of zero leaves the lane untouched. The result is registered and presented one clock after the input strobe, together with a valid flag. There is no backpressure.

Top module: `vec_round_shift`

## Requirements
- R1: `esize_i` selects the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lane i occupies bits [i*W +: W] of every vector port.
- R2: For a nonzero count c, a lane result is (x >> c) plus bit c-1 of the source lane x, truncated to W bits.
- R3: For a count of zero, a lane result equals the source lane.
- R4: When `use_imm_i`=0, the count of lane i is the low log2(W) bits of lane i of `amt_i`, read as unsigned. The upper bits of that lane are ignored.
- R5: When `use_imm_i`=1, the low log2(W) bits of `imm_i` give the count for every lane. `amt_i` and the higher `imm_i` bits are ignored.
- R6: When `arith_i`=0, lanes are treated as unsigned and vacated bits fill with zeros.
- R7: When `arith_i`=1, lanes are treated as signed and vacated bits fill with the sign bit. For example, an 8-bit 0xFD shifted by 1 gives 0xFF.
- R8: `valid_o` is high exactly one cycle after `valid_i`, and `res_o` then carries that operation's result. `res_o` holds its value while `valid_i` is low.
- R9: While `rst_ni` is low, `valid_o` and `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 256 | Source vector |
| amt_i | input | 256 | Per-lane shift counts (register form) |
| imm_i | input | 6 | Shared shift count (immediate form) |
| esize_i | input | 2 | Lane width select |
| arith_i | input | 1 | 1 = signed shift, 0 = unsigned shift |
| use_imm_i | input | 1 | 1 = use `imm_i`, 0 = use `amt_i` |
| valid_o | output | 1 | Result valid |
| res_o | output | 256 | Rounded shift result |

## Verification
The bench targets the following corner cases.

- Shift counts of W-1 on extreme values such as all-ones and the most negative value. A design that takes the rounding bit from the wrong position, or that sign-fills in unsigned mode, returns 1 where 2 is expected, or 0 where -1 is expected.
- Counts of zero. A design that always adds a rounding term would corrupt lanes that should pass unchanged.
- Register-form count lanes with junk in the high bits, and immediates with junk in the high bits. A design that does not reduce the count modulo the lane width shifts everything out.
- Random vectors under every size, mode and count source, checked lane by lane. These catch lane-boundary slicing errors and a wrong size mux.

// File: rtl/vrsh_pkg.sv
package vrsh_pkg;
  localparam int VEC_W     = 256;
  localparam int MAX_LANE  = 64;
  localparam int IMM_W     = $clog2(MAX_LANE);
  localparam int N_SIZES   = 4;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } esize_e;
endpackage

// File: rtl/vrsh_lane.sv
module vrsh_lane #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          arith_i,
  output logic [W-1:0]  y_o
);
  logic [W-1:0] shifted;
  logic         rbit;

  always_comb begin
    shifted = arith_i ? W'($signed(x_i) >>> cnt_i) : (x_i >> cnt_i);
    // last bit shifted out; sign extension never reaches it since cnt-1 < W
    rbit    = (cnt_i == '0) ? 1'b0 : x_i[cnt_i - CW'(1)];
    y_o     = (cnt_i == '0) ? x_i : W'(shifted + W'(rbit));
  end
endmodule

// File: rtl/vrsh_group.sv
module vrsh_group #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 8,
  parameter int IMM_W  = 6,
  localparam int N_LANE = VEC_W / LANE_W,
  localparam int CW     = $clog2(LANE_W)
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] amt_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             arith_i,
  input  logic             use_imm_i,
  output logic [VEC_W-1:0] res_o
);
  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    logic [CW-1:0] cnt;
    assign cnt = use_imm_i ? imm_i[CW-1:0] : amt_i[i*LANE_W +: CW];

    vrsh_lane #(.W(LANE_W)) u_lane (
      .x_i    (src_i[i*LANE_W +: LANE_W]),
      .cnt_i  (cnt),
      .arith_i(arith_i),
      .y_o    (res_o[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/vec_round_shift.sv
module vec_round_shift
  import vrsh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [255:0]     src_i,
  input  logic [255:0]     amt_i,
  input  logic [5:0]       imm_i,
  input  logic [1:0]       esize_i,
  input  logic             arith_i,
  input  logic             use_imm_i,
  output logic             valid_o,
  output logic [255:0]     res_o
);
  logic [VEC_W-1:0] grp_res [N_SIZES];
  logic [VEC_W-1:0] sel_res;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    vrsh_group #(
      .VEC_W (VEC_W),
      .LANE_W(8 << g),
      .IMM_W (IMM_W)
    ) u_grp (
      .src_i    (src_i),
      .amt_i    (amt_i),
      .imm_i    (imm_i),
      .arith_i  (arith_i),
      .use_imm_i(use_imm_i),
      .res_o    (grp_res[g])
    );
  end

  always_comb begin
    unique case (esize_e'(esize_i))
      SZ_8:    sel_res = grp_res[0];
      SZ_16:   sel_res = grp_res[1];
      SZ_32:   sel_res = grp_res[2];
      default: sel_res = grp_res[3];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= sel_res;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_no_stray_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  assert_zero_count_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && use_imm_i && imm_i == 6'd0) |=> res_o == $past(src_i));
  assert_logical_top_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esize_i == 2'd0 && !arith_i && use_imm_i && imm_i[2:0] >= 3'd2)
      |=> (res_o & {32{8'h80}}) == '0);
endmodule

// File: tb/vec_round_shift_test.sv
module vec_round_shift_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [255:0] src_i = '0;
  logic [255:0] amt_i = '0;
  logic [5:0]   imm_i = '0;
  logic [1:0]   esize_i = '0;
  logic         arith_i = 1'b0;
  logic         use_imm_i = 1'b0;
  logic         valid_o;
  logic [255:0] res_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vec_round_shift uut (.*);

  // entry: {esize[1:0], arith, x[63:0], count_lane[63:0], expected[63:0]}
  localparam int N_VEC = 14;
  localparam logic [194:0] VEC_TAB [N_VEC] = '{
    {2'd0, 1'b0, 64'h07, 64'd1, 64'h04},
    {2'd0, 1'b1, 64'hFD, 64'd1, 64'hFF},
    {2'd0, 1'b0, 64'hFF, 64'd7, 64'h02},
    {2'd0, 1'b1, 64'h80, 64'd7, 64'hFF},
    {2'd0, 1'b0, 64'h5A, 64'd0, 64'h5A},
    {2'd0, 1'b0, 64'h05, 64'd9, 64'h03},
    {2'd1, 1'b0, 64'h8000, 64'd15, 64'h0001},
    {2'd1, 1'b1, 64'hC000, 64'd15, 64'h0000},
    {2'd1, 1'b1, 64'h7FFF, 64'd1, 64'h4000},
    {2'd2, 1'b1, 64'hFFFF_FFFF, 64'd31, 64'h0},
    {2'd2, 1'b0, 64'h0000_0180, 64'd8, 64'h2},
    {2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 64'h2},
    {2'd3, 1'b1, 64'h8000_0000_0000_0000, 64'd63, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd4, 64'h0012_3456_789A_BCDF}
  };

  function automatic logic [255:0] rep(input logic [63:0] v, input logic [1:0] es);
    logic [255:0] r = '0;
    int w = 8 << es;
    for (int l = 0; l < 256 / w; l++) begin
      for (int b = 0; b < w; b++) r[l*w + b] = v[b];
    end
    return r;
  endfunction

  function automatic logic [255:0] ref_vec(input logic [255:0] s, input logic [255:0] a,
                                           input logic [5:0] im, input logic [1:0] es,
                                           input logic ar, input logic ui);
    logic [255:0] out = '0;
    int w = 8 << es;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int l = 0; l < 256 / w; l++) begin
      logic [63:0] x, lv, xs, r;
      int sh;
      x  = 64'(s >> (l*w)) & mask;
      lv = 64'(a >> (l*w)) & mask;
      sh = ui ? (int'(im) % w) : int'(lv % 64'(w));
      if (sh == 0) r = x;
      else begin
        xs = (ar && x[w-1]) ? (x | ~mask) : x;
        r  = ar ? 64'($signed(xs) >>> sh) : (xs >> sh);
        r  = (r + ((x >> (sh - 1)) & 64'd1)) & mask;
      end
      out = out | ({192'b0, r} << (l*w));
    end
    return out;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [255:0] s, input logic [255:0] a, input logic [5:0] im,
                        input logic [1:0] es, input logic ar, input logic ui,
                        input logic [255:0] exp, input string req);
    @(negedge clk_i);
    src_i = s; amt_i = a; imm_i = im; esize_i = es; arith_i = ar; use_imm_i = ui;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(valid_o === 1'b1, {req, "_R8_valid"}, {255'b0, valid_o}, 256'd1);
    check(res_o === exp, req, res_o, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0] s, a, e, last;
    logic [5:0] im;
    logic [1:0] es;
    logic ar, ui;

    // R9 reset state
    repeat (2) @(negedge clk_i);
    check(valid_o === 1'b0 && res_o === '0, "R9_reset", res_o, '0);
    rst_ni = 1'b1;

    // R1 R2 R6 R7 R4 table walk (register form, replicated lanes)
    for (int k = 0; k < N_VEC; k++) begin
      logic [194:0] t;
      t = VEC_TAB[k];
      run_op(rep(t[191:128], t[194:193]), rep(t[127:64], t[194:193]), 6'd0,
             t[194:193], t[192], 1'b0, rep(t[63:0], t[194:193]), "R2_table");
    end

    // R5 immediate with junk upper bits: 8-bit, imm=0b111001 -> count 1; amt ignored
    run_op(rep(64'h07, 2'd0), '1, 6'b111001, 2'd0, 1'b0, 1'b1, rep(64'h04, 2'd0), "R5_imm_junk");
    // R3 immediate zero on all sizes
    for (int z = 0; z < 4; z++)
      run_op({8{32'hDEAD_BEEF}}, '1, 6'd0, 2'(z), 1'b1, 1'b1, {8{32'hDEAD_BEEF}}, "R3_zero");
    // R4 per-lane differing counts, 16-bit: lane0 count 0x0011 -> 1, lane1 count 0xFFF0 -> 0
    a = '0; a[15:0] = 16'h0011; a[31:16] = 16'hFFF0;
    s = '0; s[15:0] = 16'h0003; s[31:16] = 16'h1234;
    e = '0; e[15:0] = 16'h0002; e[31:16] = 16'h1234;
    run_op(s, a, 6'd0, 2'd1, 1'b0, 1'b0, e, "R4_lane_counts");

    // R8 hold while idle
    last = res_o;
    @(negedge clk_i);
    src_i = ~src_i;
    @(negedge clk_i);
    check(valid_o === 1'b0 && res_o === last, "R8_hold", res_o, last);

    // R1 R2 R6 R7 random sweep
    for (int n = 0; n < 400; n++) begin
      s  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      a  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      im = 6'($urandom);
      es = 2'(n % 4);
      ar = n[2];
      ui = n[3];
      if (n % 16 == 15) im = 6'((8 << es) - 1);
      e = ref_vec(s, a, im, es, ar, ui);
      run_op(s, a, im, es, ar, ui, e, "R1_random");
    end

    // R9 reset mid-run clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(valid_o === 1'b0 && res_o === '0, "R9_async", res_o, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule